// File: doc/BRIEF.md
# Serial Programming Sequencer for Target Flash and EEPROM

This block is the programmer side of a four-wire serial programming link. It drives the target's reset line, serial clock and serial data input, and it reads the target's serial data output. After a `start` pulse it holds the target in reset with the clock low. It then waits out the power-up delay and sends the programming-enable frame. It checks that the target echoes the sync byte. If the echo is wrong it pulses reset again and retries, and it gives up after a set number of tries.

Once the link is in sync, the block takes one page of data items from a valid/ready input stream and writes them in one of three ways. A flash job loads each word as two load frames, low byte first, then commits the page. An EEPROM page job loads bytes and then commits. An EEPROM byte job writes each byte with its own frame and waits the write time after each one. Every frame is 32 bits, sent MSB first, and the serial clock idles low. Stream rules: `in_ready` is high only while the sequencer is waiting for the next item, and it does not depend on `in_valid`. An item moves on a clock edge where both signals are high. While `in_valid` is low the sequencer waits in place without limit. `in_data` must be stable while `in_valid` is high.

Top module: `spi_prog_seq`

## Requirements
- R1: After reset, `tgt_rst`, `tgt_sck`, `tgt_mosi`, `in_ready`, `busy`, `done` and `error` are all 0.
- R2: Each sync attempt raises `tgt_rst` for at least RST_PULSE cycles with `tgt_sck` low. Once `tgt_rst` falls, at least PWRUP_WAIT cycles pass before the next rising `tgt_sck`.
- R3: A frame is 32 bits sent MSB first. `tgt_mosi` changes only while `tgt_sck` is low, and `tgt_sck` is low between frames. The enable frame is bytes AC 53 00 00.
- R4: Inside a frame, every high phase and every low phase of `tgt_sck` lasts exactly max(`half_div`, MIN_HALF) clock cycles.
- R5: `tgt_miso` is sampled at the end of each high phase. The byte received during the third byte of the enable frame is compared with 0x53. On a mismatch the frame is still finished, reset is pulsed again, and the enable frame is resent.
- R6: After MAX_SYNC_TRIES enable frames that all mismatch, `error` rises, `done` stays low and no stream item is accepted.
- R7: With `job_mode`=0 (flash), each item becomes the frame 40 00 idx lo and then the frame 48 00 idx hi. Here idx is the item's position in the page, lo is `in_data[7:0]` and hi is `in_data[15:8]`.
- R8: A flash page ends with the commit frame 4C page 00 00. At least FLASH_WR_WAIT cycles then pass before `done` rises.
- R9: With `job_mode`=1 (EEPROM page), each item becomes C1 00 idx lo. The page ends with C2 page 00 00, and at least EE_WR_WAIT cycles pass before `done`.
- R10: With `job_mode`=2 (EEPROM byte), each item becomes C0 page idx lo. At least EE_WR_WAIT cycles pass after each such frame before the next frame or `done`.
- R11: In byte mode with `tgt_erased`=1, an item whose low byte is 0xFF is accepted but sends no frame. With `tgt_erased`=0 that item is written.
- R12: A flash job takes PAGE_WORDS items and an EEPROM job takes EE_PAGE_BYTES items, each through the valid/ready handshake. `in_ready` is never high while a frame is being shifted.
- R13: `tgt_rst` stays low for the whole of every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Starts a job; sampled only while idle |
| job_mode | input | 2 | 0 flash page, 1 EEPROM page, 2 or 3 EEPROM byte |
| tgt_erased | input | 1 | Target already erased: skip 0xFF bytes in byte mode |
| page_addr | input | 8 | Upper address bits carried by commit and byte-write frames |
| half_div | input | DIV_W | Requested serial clock half period in cycles |
| in_valid | input | 1 | Stream item valid |
| in_ready | output | 1 | Sequencer waiting for an item |
| in_data | input | 16 | Item: low byte in [7:0], high byte in [15:8] |
| busy | output | 1 | A job is running |
| done | output | 1 | Last job finished; held until the next start |
| error | output | 1 | Last job failed to sync; held until the next start |
| tgt_rst | output | 1 | Target reset level |
| tgt_sck | output | 1 | Serial clock to the target |
| tgt_mosi | output | 1 | Serial data to the target |
| tgt_miso | input | 1 | Serial data from the target |

## Verification
The bench runs six jobs against a model of the target. The model echoes the sync byte, or returns a wrong value for a chosen number of attempts. The jobs cover flash, EEPROM page and EEPROM byte modes. A clean sync, two failed syncs that then succeed, and an exhausted retry count separate the retry path from the failure path. Byte mode runs twice with the same data, which holds 0xFF bytes, once with the erased flag set and once without, so that skipping is shown to depend on that flag. Requested half periods below, at and above the minimum show that the clock divider clamps. Gaps in the input stream show that the sequencer waits for data without losing or repeating items.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;
  localparam logic [7:0] OP_ENABLE    = 8'hAC;
  localparam logic [7:0] SYNC_ECHO    = 8'h53;
  localparam logic [7:0] OP_FL_LOAD_L = 8'h40;
  localparam logic [7:0] OP_FL_LOAD_H = 8'h48;
  localparam logic [7:0] OP_FL_COMMIT = 8'h4C;
  localparam logic [7:0] OP_EE_LOAD   = 8'hC1;
  localparam logic [7:0] OP_EE_COMMIT = 8'hC2;
  localparam logic [7:0] OP_EE_BYTE   = 8'hC0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST_ON, ST_RST_OFF, ST_EN_SEND, ST_SEND, ST_SEND_W,
    ST_WAIT, ST_SYNC, ST_GET, ST_HI, ST_NEXT, ST_COMMIT_DLY,
    ST_BYTE_DLY, ST_FIN, ST_FAIL
  } seq_st_t;

  function automatic logic [31:0] mk_frame(input logic [7:0] b1, input logic [7:0] b2,
                                           input logic [7:0] b3, input logic [7:0] b4);
    return {b1, b2, b3, b4};
  endfunction
endpackage

// File: rtl/spi_wait_timer.sv
module spi_wait_timer #(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] val,
  output logic             expired
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // once run out, the timer stays expired until reloaded (R2 delays)
  p_expired_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      frame,
  input  logic [DIV_W-1:0] half_div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [7:0]       echo_byte
);
  localparam logic [DIV_W-1:0] MIN_V = DIV_W'(MIN_HALF);

  logic [31:0]      sh_q;
  logic [DIV_W-1:0] cnt_q, half_q, half_eff;
  logic [4:0]       bit_q;

  assign half_eff = (half_div < MIN_V) ? MIN_V : half_div;
  assign mosi     = busy & sh_q[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sck <= 1'b0; done <= 1'b0; cnt_q <= '0; half_q <= MIN_V;
      bit_q <= '0; sh_q <= '0; echo_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; sh_q <= frame; cnt_q <= '0; bit_q <= '0; half_q <= half_eff;
        end
      end else if (cnt_q == half_q - 1'b1) begin
        cnt_q <= '0;
        if (!sck) begin
          sck <= 1'b1;
        end else begin
          sck  <= 1'b0;
          sh_q <= {sh_q[30:0], 1'b0};
          if (bit_q[4:3] == 2'b10) echo_byte <= {echo_byte[6:0], miso};
          bit_q <= bit_q + 1'b1;
          if (bit_q == 5'd31) begin
            busy <= 1'b0; done <= 1'b1;
          end
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // checker state: length of the current sck level
  logic        sck_d;
  logic [15:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; run_q <= '0;
    end else begin
      sck_d <= sck;
      if (sck != sck_d)     run_q <= 16'd1;
      else if (run_q != '1) run_q <= run_q + 1'b1;
    end
  end

  p_sck_level_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != sck_d) |-> (run_q >= 16'(MIN_HALF)));
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  p_sck_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
endmodule

// File: rtl/spi_prog_seq.sv
module spi_prog_seq
  import spi_prog_pkg::*;
#(
  parameter int DIV_W          = 8,
  parameter int MIN_HALF       = 3,
  parameter int TMR_W          = 32,
  parameter int PWRUP_WAIT     = 2_000_000,
  parameter int RST_PULSE      = 8,
  parameter int FLASH_WR_WAIT  = 450_000,
  parameter int EE_WR_WAIT     = 900_000,
  parameter int MAX_SYNC_TRIES = 4,
  parameter int PAGE_WORDS     = 64,
  parameter int EE_PAGE_BYTES  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       job_mode,
  input  logic             tgt_erased,
  input  logic [7:0]       page_addr,
  input  logic [DIV_W-1:0] half_div,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [15:0]      in_data,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             tgt_rst,
  output logic             tgt_sck,
  output logic             tgt_mosi,
  input  logic             tgt_miso
);
  localparam int ITEMS_MAX = (PAGE_WORDS > EE_PAGE_BYTES) ? PAGE_WORDS : EE_PAGE_BYTES;
  localparam int IDX_W     = (ITEMS_MAX > 1) ? $clog2(ITEMS_MAX) : 1;
  localparam int TRY_W     = (MAX_SYNC_TRIES > 1) ? $clog2(MAX_SYNC_TRIES) : 1;

  seq_st_t          st_q, ret_q;
  logic [31:0]      frame_q;
  logic [TRY_W-1:0] tries_q;
  logic [IDX_W-1:0] idx_q, last_idx;
  logic [15:0]      data_q;
  logic [1:0]       mode_q;
  logic             erased_q, rst_q, done_q, err_q;
  logic [7:0]       page_q, echo_byte;
  logic             sh_start, sh_busy, sh_done, tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_val;
  logic             is_byte, is_eepage;

  assign is_byte   = mode_q[1];
  assign is_eepage = (mode_q == 2'd1);
  assign last_idx  = (mode_q == 2'd0) ? IDX_W'(PAGE_WORDS - 1) : IDX_W'(EE_PAGE_BYTES - 1);
  assign sh_start  = (st_q == ST_SEND);
  assign in_ready  = (st_q == ST_GET);
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign error     = err_q;
  assign tgt_rst   = rst_q;

  always_comb begin
    tmr_load = 1'b1;
    case (st_q)
      ST_RST_ON:     tmr_val = TMR_W'(RST_PULSE);
      ST_RST_OFF:    tmr_val = TMR_W'(PWRUP_WAIT);
      ST_COMMIT_DLY: tmr_val = is_eepage ? TMR_W'(EE_WR_WAIT) : TMR_W'(FLASH_WR_WAIT);
      ST_BYTE_DLY:   tmr_val = TMR_W'(EE_WR_WAIT);
      default: begin tmr_load = 1'b0; tmr_val = '0; end
    endcase
  end

  spi_wait_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_exp));

  spi_bit_engine #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .frame(frame_q), .half_div(half_div),
    .miso(tgt_miso), .sck(tgt_sck), .mosi(tgt_mosi), .busy(sh_busy), .done(sh_done),
    .echo_byte(echo_byte));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ret_q <= ST_IDLE; frame_q <= '0; tries_q <= '0; idx_q <= '0;
      data_q <= '0; mode_q <= '0; erased_q <= 1'b0; page_q <= '0;
      rst_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          mode_q <= job_mode; erased_q <= tgt_erased; page_q <= page_addr;
          tries_q <= '0; done_q <= 1'b0; err_q <= 1'b0; st_q <= ST_RST_ON;
        end
        ST_RST_ON:  begin rst_q <= 1'b1; ret_q <= ST_RST_OFF; st_q <= ST_WAIT; end
        ST_RST_OFF: begin rst_q <= 1'b0; ret_q <= ST_EN_SEND; st_q <= ST_WAIT; end
        ST_EN_SEND: begin
          frame_q <= mk_frame(OP_ENABLE, SYNC_ECHO, 8'h00, 8'h00);
          ret_q <= ST_SYNC; st_q <= ST_SEND;
        end
        ST_SEND:   st_q <= ST_SEND_W;
        ST_SEND_W: if (sh_done) st_q <= ret_q;
        ST_WAIT:   if (tmr_exp) st_q <= ret_q;
        ST_SYNC: begin
          if (echo_byte == SYNC_ECHO) begin
            idx_q <= '0; st_q <= ST_GET;
          end else if (tries_q == TRY_W'(MAX_SYNC_TRIES - 1)) begin
            st_q <= ST_FAIL;
          end else begin
            tries_q <= tries_q + 1'b1; st_q <= ST_RST_ON;
          end
        end
        ST_GET: if (in_valid) begin
          data_q <= in_data;
          if (is_byte) begin
            if (erased_q && in_data[7:0] == 8'hFF) st_q <= ST_NEXT;
            else begin
              frame_q <= mk_frame(OP_EE_BYTE, page_q, 8'(idx_q), in_data[7:0]);
              ret_q <= ST_BYTE_DLY; st_q <= ST_SEND;
            end
          end else if (is_eepage) begin
            frame_q <= mk_frame(OP_EE_LOAD, 8'h00, 8'(idx_q), in_data[7:0]);
            ret_q <= ST_NEXT; st_q <= ST_SEND;
          end else begin
            frame_q <= mk_frame(OP_FL_LOAD_L, 8'h00, 8'(idx_q), in_data[7:0]);
            ret_q <= ST_HI; st_q <= ST_SEND;
          end
        end
        ST_HI: begin
          frame_q <= mk_frame(OP_FL_LOAD_H, 8'h00, 8'(idx_q), data_q[15:8]);
          ret_q <= ST_NEXT; st_q <= ST_SEND;
        end
        ST_NEXT: begin
          if (idx_q == last_idx) begin
            if (is_byte) st_q <= ST_FIN;
            else begin
              frame_q <= mk_frame(is_eepage ? OP_EE_COMMIT : OP_FL_COMMIT, page_q, 8'h00, 8'h00);
              ret_q <= ST_COMMIT_DLY; st_q <= ST_SEND;
            end
          end else begin
            idx_q <= idx_q + 1'b1; st_q <= ST_GET;
          end
        end
        ST_COMMIT_DLY: begin ret_q <= ST_FIN; st_q <= ST_WAIT; end
        ST_BYTE_DLY:   begin ret_q <= ST_NEXT; st_q <= ST_WAIT; end
        ST_FIN:        begin done_q <= 1'b1; st_q <= ST_IDLE; end
        ST_FAIL:       begin err_q <= 1'b1; st_q <= ST_IDLE; end
        default:       st_q <= ST_IDLE;
      endcase
    end
  end

  p_rst_low_in_frame_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> !tgt_rst);
  p_ready_engine_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !sh_busy);
  p_status_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  p_ready_sched_after_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> !tgt_rst);
endmodule

// File: tb/spi_prog_seq_tb_top.sv
module spi_prog_seq_tb_top;
  localparam int DIV_W = 8, MIN_HALF = 3, PWRUP = 60, RSTP = 4, FLWR = 40, EEWR = 30;
  localparam int MAXT = 3, PW = 4, EB = 4;

  typedef struct packed {
    logic [1:0] mode; logic erased; logic [7:0] page;
    logic [1:0] bad;  logic [3:0] ffmask; logic [7:0] half;
  } job_t;
  localparam job_t JOBS [0:5] = '{
    '{2'd0, 1'b0, 8'h12, 2'd0, 4'h0, 8'd2},
    '{2'd0, 1'b0, 8'h34, 2'd2, 4'h0, 8'd5},
    '{2'd1, 1'b0, 8'h56, 2'd1, 4'h0, 8'd3},
    '{2'd2, 1'b1, 8'h78, 2'd0, 4'h5, 8'd4},
    '{2'd2, 1'b0, 8'h9A, 2'd0, 4'h5, 8'd3},
    '{2'd0, 1'b0, 8'hBC, 2'd3, 4'h0, 8'd3}};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tgt_erased = 1'b0, in_valid = 1'b0;
  logic [1:0] job_mode = '0;
  logic [7:0] page_addr = '0;
  logic [DIV_W-1:0] half_div = '0;
  logic [15:0] in_data = '0;
  logic in_ready, busy, done, error, tgt_rst, tgt_sck, tgt_mosi;
  logic tgt_miso = 1'b0;

  always #2 clk = ~clk;

  spi_prog_seq #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF), .TMR_W(16), .PWRUP_WAIT(PWRUP),
    .RST_PULSE(RSTP), .FLASH_WR_WAIT(FLWR), .EE_WR_WAIT(EEWR), .MAX_SYNC_TRIES(MAXT),
    .PAGE_WORDS(PW), .EE_PAGE_BYTES(EB)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .job_mode(job_mode), .tgt_erased(tgt_erased),
    .page_addr(page_addr), .half_div(half_div), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .busy(busy), .done(done), .error(error), .tgt_rst(tgt_rst),
    .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi), .tgt_miso(tgt_miso));

  int tests = 0, fails = 0;
  logic wd = 1'b0;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // target model and line monitor, sampled on the falling clock edge
  int cyc = 0, bcm = 0, run = 0, ncap = 0, bad_left = 0;
  int min_hi, min_lo, min_rw, min_gap, v_rst, v_mosi, r_rise, r_fall, st_cyc, done_cyc;
  logic arm = 1'b0, pend = 1'b0, p_sck = 1'b0, p_rst = 1'b0, p_mosi = 1'b0, p_done = 1'b0;
  logic [31:0] rxm = '0;
  logic [7:0] echo = '0;
  logic [31:0] cap [0:63];
  int cap_st [0:63];
  int cap_end [0:63];

  always @(negedge clk) begin
    cyc++;
    if (tgt_rst) bcm = 0;
    if (tgt_rst && !p_rst) r_rise = cyc;
    if (!tgt_rst && p_rst) begin
      if (cyc - r_rise < min_rw) min_rw = cyc - r_rise;
      r_fall = cyc; arm = 1'b1;
    end
    if (tgt_sck != p_sck) begin
      if (tgt_sck) begin
        if (tgt_rst) v_rst++;
        if (arm) begin
          if (cyc - r_fall < min_gap) min_gap = cyc - r_fall;
          arm = 1'b0;
        end
        if (bcm != 0 && run < min_lo) min_lo = run;
        if (bcm == 0) st_cyc = cyc;
        rxm = {rxm[30:0], tgt_mosi};
        bcm++;
        if (bcm == 32) begin
          if (ncap < 64) begin cap[ncap] = rxm; cap_st[ncap] = st_cyc; ncap++; end
          bcm = 0; pend = 1'b1;
          if (rxm == 32'hAC530000 && bad_left > 0) bad_left--;
        end
      end else begin
        if (run < min_hi) min_hi = run;
        if (pend) begin cap_end[ncap-1] = cyc; pend = 1'b0; end
        if (bcm == 16) echo = (bad_left == 0) ? rxm[7:0] : 8'h00;
        if (bcm >= 16 && bcm <= 23) tgt_miso = echo[23-bcm];
        else tgt_miso = 1'b0;
      end
      run = 1;
    end else run++;
    if (tgt_sck && p_sck && tgt_mosi != p_mosi) v_mosi++;
    if (done && !p_done) done_cyc = cyc;
    p_sck = tgt_sck; p_rst = tgt_rst; p_mosi = tgt_mosi; p_done = done;
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd = 1'b1;
  end

  function automatic logic [15:0] item(input int j, input int k, input logic [3:0] m);
    logic [7:0] lo, hi;
    lo = m[k] ? 8'hFF : 8'(32 + k + 4 * j);
    hi = 8'(160 + k + 8 * j);
    return {hi, lo};
  endfunction

  logic [31:0] expf [0:63];
  int nexp, xfers;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({tgt_rst, tgt_sck, tgt_mosi, in_ready, busy, done, error} == 7'b0, "R1 reset outputs",
        {tgt_rst, tgt_sck, tgt_mosi, in_ready, busy, done, error}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({tgt_rst, in_ready, busy, done, error} == 5'b0, "R1 idle after reset",
        {tgt_rst, in_ready, busy, done, error}, 0);

    for (int j = 0; j < 6; j++) begin
      automatic job_t jb = JOBS[j];
      automatic int he = (int'(jb.half) < MIN_HALF) ? MIN_HALF : int'(jb.half);
      automatic int nen = (int'(jb.bad) >= MAXT) ? MAXT : int'(jb.bad) + 1;
      automatic logic fail_exp = (int'(jb.bad) >= MAXT);
      automatic int nit = (jb.mode == 2'd0) ? PW : EB;
      // expected frame list from the requirements
      nexp = 0;
      for (int e = 0; e < nen; e++) begin expf[nexp] = 32'hAC530000; nexp++; end
      if (!fail_exp) begin
        for (int k = 0; k < nit; k++) begin
          automatic logic [15:0] d = item(j, k, jb.ffmask);
          if (jb.mode == 2'd0) begin
            expf[nexp] = {8'h40, 8'h00, 8'(k), d[7:0]}; nexp++;
            expf[nexp] = {8'h48, 8'h00, 8'(k), d[15:8]}; nexp++;
          end else if (jb.mode == 2'd1) begin
            expf[nexp] = {8'hC1, 8'h00, 8'(k), d[7:0]}; nexp++;
          end else if (!(jb.erased && d[7:0] == 8'hFF)) begin
            expf[nexp] = {8'hC0, jb.page, 8'(k), d[7:0]}; nexp++;
          end
        end
        if (jb.mode == 2'd0) begin expf[nexp] = {8'h4C, jb.page, 16'h0}; nexp++; end
        if (jb.mode == 2'd1) begin expf[nexp] = {8'hC2, jb.page, 16'h0}; nexp++; end
      end
      // arm monitor
      ncap = 0; bad_left = int'(jb.bad); min_hi = 1000; min_lo = 1000; min_rw = 1000;
      min_gap = 100000; v_rst = 0; v_mosi = 0; xfers = 0; done_cyc = 0;
      job_mode = jb.mode; tgt_erased = jb.erased; page_addr = jb.page; half_div = jb.half;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      // stream feeder with gaps
      for (int k = 0; k < nit; k++) begin
        if (done || error || wd) break;
        repeat (k % 3) @(negedge clk);
        in_valid = 1'b1; in_data = item(j, k, jb.ffmask);
        while (!in_ready && !(done || error || wd)) @(negedge clk);
        if (in_ready) begin xfers++; @(negedge clk); end
        in_valid = 1'b0;
      end
      while (!(done || error || wd)) @(negedge clk);
      repeat (2) @(negedge clk);

      chk(error == fail_exp && done == !fail_exp, fail_exp ? "R6 error status" : "R5 done status",
          {done, error}, {!fail_exp, fail_exp});
      chk(ncap == nexp, "R3 frame count", ncap, nexp);
      for (int i = 0; i < nexp && i < ncap; i++)
        chk(cap[i] == expf[i], (jb.mode == 2'd0) ? "R7 R8 flash frame" :
            (jb.mode == 2'd1) ? "R9 eeprom page frame" : "R10 R11 byte frame", cap[i], expf[i]);
      chk(xfers == (fail_exp ? 0 : nit), "R12 R11 items accepted", xfers, fail_exp ? 0 : nit);
      chk(min_hi == he && min_lo == he, "R4 sck half period", {min_hi, min_lo}, {he, he});
      chk(v_mosi == 0, "R3 mosi stable while sck high", v_mosi, 0);
      chk(v_rst == 0, "R13 reset low during frames", v_rst, 0);
      chk(min_rw >= RSTP, "R2 reset pulse width", min_rw, RSTP);
      chk(min_gap >= PWRUP, "R2 power-up wait", min_gap, PWRUP);
      if (!fail_exp && ncap > 0) begin
        automatic int need = (jb.mode == 2'd0) ? FLWR : EEWR;
        chk(done_cyc - cap_end[ncap-1] >= need, "R8 R9 R10 final write wait",
            done_cyc - cap_end[ncap-1], need);
        if (jb.mode[1])
          for (int i = nen; i + 1 < ncap; i++)
            chk(cap_st[i+1] - cap_end[i] >= EEWR, "R10 byte write spacing",
                cap_st[i+1] - cap_end[i], EEWR);
      end
    end
    chk(!wd, "watchdog", wd, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule